// File: doc/BRIEF.md
# DMA Channel Launch Control

This block decides when each channel of a multi-channel descriptor DMA may start and from which address its next descriptor is fetched. Software arms channels through a shared trigger word, which also carries a per-channel restart request. Each channel also has a control word with enable and pause bits, and a 48-bit chain head address split over two words.

When a channel is triggered, enabled and not paused, the block issues one fetch request to a downstream descriptor fetcher. The request carries the channel number and the descriptor address. The address is the chain head if the channel's previous chain ended or a restart was requested. Otherwise it is the next-descriptor pointer the fetcher returned with the previous descriptor. The fetcher acknowledges the request and later reports completion, with either a next pointer or an end-of-chain flag. The end-of-chain flag covers the last descriptor, the last descriptor of a frame, and any error.

Only one request is in flight at a time. Ready channels are served lowest number first. A trigger stays set until software rewrites that channel's control word, so a triggered channel keeps following its chain and restarts at the head once the chain ends.

Top module: `dma_launch_ctrl`

## Requirements
- R1: After reset no request is raised, all triggers, restart requests, control words and addresses are zero, and every channel counts as finished, so its first fetch uses the chain head.
- R2: A write to the trigger word (word address 0x00) ORs bits NCH-1:0 into the channel triggers and bits 2*NCH-1:NCH into the restart requests; bits already set stay set.
- R3: Reading the trigger word always returns zero.
- R4: Writing channel n's control word (word address 0x10+4n) clears trigger n and stores bits 29:0, which read back with bits 31:30 as zero; bit 0 is enable and bit 1 is pause.
- R5: A channel is launched only while it is triggered, enabled and not paused; otherwise no request is raised for it.
- R6: The chain head of channel n is {upper word 0x12+4n bits 15:0, lower word 0x11+4n}; the upper word keeps only 16 bits on readback. It is the fetch address when the channel is finished or has a restart request.
- R7: Otherwise the fetch address is the next pointer reported with the channel's last completion.
- R8: A launch consumes the channel's restart request, and a launch from the chain head clears the channel's finished state.
- R9: A completion with the end flag set marks the channel finished; without it, the reported next pointer is stored for the channel.
- R10: When several channels are ready, the lowest-numbered one is launched.
- R11: A raised request holds its channel and address unchanged until acknowledged, and no new request is raised before the completion of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RA | Register word address, used for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_ack | input | 1 | Fetcher accepts the request |
| fetch_ch | output | CW | Channel of the request |
| fetch_addr | output | AW | Descriptor address of the request |
| done_valid | input | 1 | Completion of the in-flight descriptor |
| done_last | input | 1 | Chain ended (last, last of frame, or error) |
| done_next | input | AW | Next-descriptor pointer of the completed descriptor |

## Verification
The bench builds the block with six channels, 48-bit addresses and an 8-bit register address. At these values the trigger word uses 12 bits, split evenly between triggers and restart requests. The chain head upper word keeps 16 significant bits, so truncation of wider writes is visible on readback. Six channels give enough simultaneous ready sets to exercise the priority order and starvation of higher channels under random arming.

// File: rtl/dma_launch_ctrl.sv
module dma_launch_ctrl #(
  parameter int NCH = 6,
  parameter int AW  = 48,
  parameter int RA  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              fetch_req,
  input  logic              fetch_ack,
  output logic [$clog2(NCH)-1:0] fetch_ch,
  output logic [AW-1:0]     fetch_addr,
  input  logic              done_valid,
  input  logic              done_last,
  input  logic [AW-1:0]     done_next
);
  localparam int CW    = $clog2(NCH);
  localparam int HW    = AW - 32;
  localparam int CBASE = 16;

  logic [NCH-1:0] trig, rtrg, fin, ready, ctl_wr, pick_oh, ch_oh;
  logic [29:0]    ctl [NCH];
  logic [31:0]    lo  [NCH];
  logic [HW-1:0]  hi  [NCH];
  logic [AW-1:0]  nxt [NCH];
  logic [CW-1:0]  pick;
  logic           req_q, wait_q, launch, use_start, glb_wr, done_take;
  logic [AW-1:0]  start_sel;

  assign glb_wr    = reg_wr && reg_addr == '0;
  assign launch    = !req_q && !wait_q && |ready;
  assign done_take = wait_q && done_valid;
  assign pick_oh   = NCH'(1) << pick;
  assign ch_oh     = NCH'(1) << fetch_ch;
  assign use_start = |((fin | rtrg) & pick_oh);
  assign start_sel = {hi[pick], lo[pick]};
  assign fetch_req = req_q;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (ready[i]) pick = CW'(i);
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign ready[n]  = trig[n] && ctl[n][0] && !ctl[n][1];
    assign ctl_wr[n] = reg_wr && reg_addr == RA'(CBASE + 4 * n);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctl[n] <= '0;
        lo[n]  <= '0;
        hi[n]  <= '0;
        nxt[n] <= '0;
      end else begin
        if (ctl_wr[n]) ctl[n] <= reg_wdata[29:0];
        if (reg_wr && reg_addr == RA'(CBASE + 4 * n + 1)) lo[n] <= reg_wdata;
        if (reg_wr && reg_addr == RA'(CBASE + 4 * n + 2)) hi[n] <= reg_wdata[HW-1:0];
        if (done_take && !done_last && fetch_ch == CW'(n)) nxt[n] <= done_next;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int n = 0; n < NCH; n++) begin
      if (reg_addr == RA'(CBASE + 4 * n))     reg_rdata = {2'b00, ctl[n]};
      if (reg_addr == RA'(CBASE + 4 * n + 1)) reg_rdata = lo[n];
      if (reg_addr == RA'(CBASE + 4 * n + 2)) reg_rdata = 32'(hi[n]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig       <= '0;
      rtrg       <= '0;
      fin        <= '1;
      req_q      <= 1'b0;
      wait_q     <= 1'b0;
      fetch_ch   <= '0;
      fetch_addr <= '0;
    end else begin
      trig <= (trig & ~ctl_wr) | (glb_wr ? reg_wdata[NCH-1:0] : '0);
      rtrg <= (rtrg & ~(launch ? pick_oh : '0)) | (glb_wr ? reg_wdata[2*NCH-1:NCH] : '0);
      if (launch) begin
        req_q      <= 1'b1;
        fetch_ch   <= pick;
        fetch_addr <= use_start ? start_sel : nxt[pick];
        if (use_start) fin <= fin & ~pick_oh;
      end
      if (req_q && fetch_ack) begin
        req_q  <= 1'b0;
        wait_q <= 1'b1;
      end
      if (done_take) begin
        wait_q <= 1'b0;
        if (done_last) fin <= fin | ch_oh;
      end
    end
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !fetch_ack |=> fetch_req && $stable(fetch_ch) && $stable(fetch_addr));
  assert_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_req) |-> $past(!wait_q));
  assert_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_req) |-> |($past(ready) & ch_oh));
  assert_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_req) |-> ($past(ready) & ~({NCH{1'b1}} << fetch_ch)) == '0);
  assert_rtrg_used_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_req) && !$past(glb_wr) |-> !(|(rtrg & ch_oh)));
  assert_fin_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_req) && |($past(fin) & ch_oh) |-> !(|(fin & ch_oh)));
endmodule

// File: tb/test_dma_launch_ctrl.sv
`timescale 1ns/1ps
module test_dma_launch_ctrl;
  localparam int NCH = 6, AW = 48, RA = 8, CW = 3;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, fetch_ack = 0, done_valid = 0, done_last = 0;
  logic [RA-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic fetch_req;
  logic [CW-1:0] fetch_ch;
  logic [AW-1:0] fetch_addr, done_next = '0;

  dma_launch_ctrl #(.NCH(NCH), .AW(AW), .RA(RA)) i_dma_launch_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_req(fetch_req),
    .fetch_ack(fetch_ack), .fetch_ch(fetch_ch), .fetch_addr(fetch_addr),
    .done_valid(done_valid), .done_last(done_last), .done_next(done_next));

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  bit finished_run = 0;

  logic [NCH-1:0] m_trig = '0, m_rtrg = '0, m_fin = '1;
  logic [29:0] m_ctl [NCH];
  logic [31:0] m_lo [NCH];
  logic [15:0] m_hi [NCH];
  logic [AW-1:0] m_next [NCH];

  function automatic logic [RA-1:0] ca(int n, int k);
    return RA'(16 + 4 * n + k);
  endfunction

  function automatic logic [NCH-1:0] m_ready();
    logic [NCH-1:0] r;
    for (int i = 0; i < NCH; i++) r[i] = m_trig[i] && m_ctl[i][0] && !m_ctl[i][1];
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [RA-1:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (a == 0) begin
      m_trig |= d[NCH-1:0];
      m_rtrg |= d[2*NCH-1:NCH];
    end
    for (int n = 0; n < NCH; n++) begin
      if (a == ca(n, 0)) begin m_ctl[n] = d[29:0]; m_trig[n] = 0; end
      if (a == ca(n, 1)) m_lo[n] = d;
      if (a == ca(n, 2)) m_hi[n] = d[15:0];
    end
  endtask

  task automatic rd_chk(logic [RA-1:0] a, logic [31:0] exp, string tag);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic check_launch(string tag, output bit launched);
    logic [NCH-1:0] r = m_ready();
    int ch = 0;
    logic [AW-1:0] ea;
    launched = |r;
    if (!launched) begin
      chk(fetch_req == 0, tag, fetch_req, 0);
      return;
    end
    for (int i = NCH - 1; i >= 0; i--) if (r[i]) ch = i;
    ea = (m_fin[ch] || m_rtrg[ch]) ? {m_hi[ch], m_lo[ch]} : m_next[ch];
    if (m_fin[ch] || m_rtrg[ch]) m_fin[ch] = 0;
    m_rtrg[ch] = 0;
    chk(fetch_req == 1, {tag, " req"}, fetch_req, 1);
    chk(fetch_ch == CW'(ch), {tag, " R10 channel"}, fetch_ch, ch);
    chk(fetch_addr == ea, {tag, " address"}, fetch_addr, ea);
    repeat ($urandom_range(0, 2)) begin
      @(negedge clk);
      chk(fetch_req && fetch_addr == ea && fetch_ch == CW'(ch), "R11 hold", fetch_addr, ea);
    end
    fetch_ack = 1;
    @(negedge clk);
    fetch_ack = 0;
  endtask

  task automatic complete(bit last, logic [AW-1:0] nx);
    int ch = int'(fetch_ch);
    done_valid = 1; done_last = last; done_next = nx;
    @(negedge clk);
    done_valid = 0;
    if (last) m_fin[ch] = 1; else m_next[ch] = nx;
    @(negedge clk);
  endtask

  task automatic rand_write();
    int k = $urandom_range(0, 9);
    int n = $urandom_range(0, NCH - 1);
    logic [31:0] d = $urandom;
    if (k < 2) begin
      d = 32'(1) << n;
      if ($urandom_range(0, 3) == 0) d |= 32'(1) << (NCH + $urandom_range(0, NCH - 1));
      wr(0, d);
    end else if (k < 6) begin
      d[0] = ($urandom_range(0, 4) != 0);
      d[1] = ($urandom_range(0, 4) == 0);
      wr(ca(n, 0), d);
    end else if (k < 8) wr(ca(n, 1), d);
    else wr(ca(n, 2), d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished_run) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit l;
    void'($urandom(32'h5eed));
    for (int i = 0; i < NCH; i++) begin
      m_ctl[i] = '0; m_lo[i] = '0; m_hi[i] = '0; m_next[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(fetch_req == 0, "R1 no request", fetch_req, 0);
    rd_chk(ca(2, 0), 0, "R1 control zero");
    rd_chk(ca(4, 2), 0, "R1 upper zero");
    wr(ca(0, 0), 32'hFFFF_FFFC);
    rd_chk(ca(0, 0), 32'h3FFF_FFFC, "R4 control bits 29:0");
    wr(ca(0, 2), 32'hABCD_1234);
    rd_chk(ca(0, 2), 32'h0000_1234, "R6 upper 16 bits");
    wr(0, 32'h0000_0040);
    rd_chk(0, 0, "R3 trigger reads zero");
    // channel 2 chain walk
    wr(ca(2, 1), 32'h1000_0000);
    wr(ca(2, 2), 32'h0000_00A5);
    wr(ca(2, 0), 32'h1);
    wr(0, 32'h4);
    @(negedge clk);
    check_launch("R1 R6 head after reset", l);
    complete(0, 48'h0000_2222_3330);
    check_launch("R7 next pointer", l);
    wr(0, 32'h4 << NCH);
    complete(0, 48'h0000_4444_5550);
    check_launch("R8 restart consumed", l);
    complete(0, 48'h0000_6666_7770);
    check_launch("R7 after restart", l);
    complete(1, 48'h0);
    check_launch("R9 end returns to head", l);
    wr(ca(2, 0), 32'h3);
    complete(0, 48'h0000_0000_0100);
    check_launch("R4 R5 cleared and paused", l);
    wr(0, 32'h4);
    @(negedge clk);
    check_launch("R5 paused no launch", l);
    wr(ca(2, 0), 32'h1);
    @(negedge clk);
    check_launch("R4 trigger cleared", l);
    wr(ca(1, 0), 32'h1);
    wr(ca(3, 0), 32'h1);
    wr(0, 32'h0A);
    @(negedge clk);
    check_launch("R10 R2 lowest first", l);
    // random phase
    for (int it = 0; it < 3000; it++) begin
      if (l) begin
        repeat ($urandom_range(0, 3)) rand_write();
        complete($urandom_range(0, 2) == 0, {$urandom, $urandom} & {{(AW-4){1'b1}}, 4'h0});
      end else begin
        rand_write();
        @(negedge clk);
      end
      check_launch("R2 R5 R6 R7 R8 R9 R10 random", l);
    end
    finished_run = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule